// File: doc/BRIEF.md
# Echo-Confirmed Mailbox Notifier

This block moves 32-bit event tokens over a single-word mailbox that has no flow control, so delivery has to be confirmed by the protocol itself. On the sending side, a user request writes a token to the outbound mailbox port. The block then waits for the far side to write a reply into the inbound mailbox. That reply reaches the block through a mailbox-not-empty interrupt. The reply is compared with the sent token, and the block reports one of three outcomes: delivered, wrong echo, or no answer within a fixed window. The window is a cycle count derived from the clock frequency and a millisecond parameter, with 500 ms by default.

The same block also holds the answering side. Tokens whose top byte is all ones are reserved for system events. Two of them are defined: 0xFF000001 asks the console to stop all cartridge IO, and 0xFF000002 asks for a soft reboot. When such a token arrives while the block is idle and the mailbox interrupt is asserted, the block pulses the matching action output and writes the same value back as the echo. It keeps doing so after a halt event. The inbound interrupt has a pending flag, an enable and a clear, all controlled through one interrupt-control word. Console resets and register locking wipe the flag and the enable.

Top module: `mbox_echo_link`

## Requirements
- R1: After reset, `statusWord`, `irqOut`, `rspValid`, `reqBusy`, `mbxOutValid`, `haltPulse` and `rebootPulse` are all 0.
- R2: A request accepted while idle drives `mbxOutValid` high for one cycle, with `mbxOutData` equal to the token, in the cycle after the accepting edge.
- R3: While a reply is awaited, an asserted interrupt with inbound data equal to the sent token gives `rspValid` with `rspCode` 1 (delivered), one cycle after the inbound write. The pending flag is cleared at the same edge.
- R4: While a reply is awaited, an asserted interrupt with inbound data different from the sent token gives `rspValid` with `rspCode` 2 (wrong echo).
- R5: If no interrupt is seen, `rspValid` with `rspCode` 3 (no answer) comes exactly TIMEOUT_CYCLES cycles after the accepting edge. A reply that raises the interrupt by the edge before expiry wins over the timeout.
- R6: A request made while a reply is awaited raises `reqBusy` for one cycle. It causes no outbound write and is not queued. The original exchange is unaffected.
- R7: An inbound write sets the pending flag (`statusWord` bit 23) and latches the data. `irqOut` is pending AND enable, and the enable is visible on `statusWord` bit 22.
- R8: In the interrupt-control word, bit 8 enables and bit 9 disables; with both set, disable wins. Writing bit 28 clears the pending flag, but an inbound write in the same cycle leaves it set.
- R9: When idle with `irqOut` high and inbound token 0xFF000001 (or 0xFF000002), the next cycle shows a one-cycle `haltPulse` (or `rebootPulse`) and an outbound write of the same token, and the pending flag is cleared. Events are still answered after a halt.
- R10: When idle, any other inbound token is neither echoed nor acted on, including an undefined reserved token; its pending flag stays set.
- R11: A pulse on `consoleRst` or `regLock` clears both the pending flag and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | User send request |
| reqToken | input | 32 | Token to send |
| reqBusy | output | 1 | Request refused, exchange in progress |
| rspValid | output | 1 | Outcome strobe |
| rspCode | output | 2 | 1 delivered, 2 wrong echo, 3 no answer |
| mbxOutValid | output | 1 | Outbound mailbox write strobe |
| mbxOutData | output | 32 | Outbound mailbox word |
| mbxInValid | input | 1 | Inbound mailbox write by the far side |
| mbxInData | input | 32 | Inbound mailbox word |
| icWrite | input | 1 | Interrupt-control word write strobe |
| icData | input | 32 | Interrupt-control word (bit 8 enable, 9 disable, 28 clear) |
| statusWord | output | 32 | Bit 23 pending, bit 22 enable, others 0 |
| irqOut | output | 1 | Mailbox interrupt line |
| consoleRst | input | 1 | Hard or NMI reset event |
| regLock | input | 1 | Register-access lock event |
| haltPulse | output | 1 | Halt-IO event action |
| rebootPulse | output | 1 | Soft-reboot event action |

## Verification
The outbound token is due one cycle after the accepting edge, and outcomes and echoes one cycle after the inbound write edge. A timeout is due exactly TIMEOUT_CYCLES edges after acceptance. The bench counts edges from the accepting edge and records the edge at which `rspValid` first appears. It compares that edge number and the code with values derived from the reply delay in each table vector. All inputs change and all outputs are sampled on the falling edge, so each sample reflects exactly the rising edge before it. This includes the edge where reply and expiry coincide.

// File: rtl/mbox_echo_pkg.sv
package mbox_echo_pkg;
  localparam int TOKEN_W      = 32;
  localparam int STAT_PEND    = 23;
  localparam int STAT_EN      = 22;
  localparam int IC_EN_BIT    = 8;
  localparam int IC_DIS_BIT   = 9;
  localparam int IC_CLR_BIT   = 28;
  localparam logic [TOKEN_W-1:0] HALT_TOKEN   = 32'hFF00_0001;
  localparam logic [TOKEN_W-1:0] REBOOT_TOKEN = 32'hFF00_0002;

  typedef enum logic [1:0] {
    RSP_NONE     = 2'd0,
    RSP_OK       = 2'd1,
    RSP_MISMATCH = 2'd2,
    RSP_TIMEOUT  = 2'd3
  } rspCode_e;

  typedef struct packed {
    logic sendReq;
    logic sendEcho;
    logic ackRx;
    logic timerRun;
  } ctlStrobe_t;
endpackage

// File: rtl/mbox_echo_dp.sv
module mbox_echo_dp
  import mbox_echo_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 50_000_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [TOKEN_W-1:0] reqToken,
  input  logic               mbxInValid,
  input  logic [TOKEN_W-1:0] mbxInData,
  input  logic               icWrite,
  input  logic [TOKEN_W-1:0] icData,
  input  logic               flush,
  output logic               mbxOutValid,
  output logic [TOKEN_W-1:0] mbxOutData,
  output logic               irqLine,
  output logic [TOKEN_W-1:0] statusWord,
  output logic               rxMatch,
  output logic               rxIsHalt,
  output logic               rxIsReboot,
  output logic               timeoutHit
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [TOKEN_W-1:0] txReg, rxData;
  logic               pending, enable;
  logic [CNT_W-1:0]   waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      enable  <= 1'b0;
    end else if (flush) begin
      pending <= 1'b0;
      enable  <= 1'b0;
    end else begin
      if (mbxInValid)
        pending <= 1'b1;
      else if (ctl.ackRx || (icWrite && icData[IC_CLR_BIT]))
        pending <= 1'b0;
      if (icWrite) begin
        if (icData[IC_DIS_BIT])     enable <= 1'b0;
        else if (icData[IC_EN_BIT]) enable <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      txReg       <= '0;
      mbxOutData  <= '0;
      mbxOutValid <= 1'b0;
    end else begin
      if (mbxInValid) rxData <= mbxInData;
      if (ctl.sendReq) txReg <= reqToken;
      mbxOutValid <= ctl.sendReq || ctl.sendEcho;
      if (ctl.sendReq)       mbxOutData <= reqToken;
      else if (ctl.sendEcho) mbxOutData <= rxData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.timerRun) waitCnt <= '0;
    else if (!timeoutHit)       waitCnt <= waitCnt + 1'b1;
  end

  always_comb begin
    statusWord            = '0;
    statusWord[STAT_PEND] = pending;
    statusWord[STAT_EN]   = enable;
  end

  assign irqLine    = pending && enable;
  assign rxMatch    = (rxData == txReg);
  assign rxIsHalt   = (rxData == HALT_TOKEN);
  assign rxIsReboot = (rxData == REBOOT_TOKEN);
  assign timeoutHit = (waitCnt == CNT_LAST);

  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_LAST);
  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !pending && !enable);
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (icWrite && icData[IC_CLR_BIT] && !mbxInValid) |=> !pending);
  p_arrival_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mbxInValid && !flush) |=> pending && rxData == $past(mbxInData));
endmodule

// File: rtl/mbox_echo_ctl.sv
module mbox_echo_ctl
  import mbox_echo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       irqLine,
  input  logic       rxMatch,
  input  logic       rxIsHalt,
  input  logic       rxIsReboot,
  input  logic       timeoutHit,
  output ctlStrobe_t ctl,
  output logic       reqBusy,
  output logic       rspValid,
  output rspCode_e   rspCode,
  output logic       haltPulse,
  output logic       rebootPulse
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e   state, nState;
  logic     busyN, rspValidN, haltN, rebootN;
  rspCode_e rspCodeN;

  always_comb begin
    ctl       = '0;
    nState    = state;
    busyN     = 1'b0;
    rspValidN = 1'b0;
    rspCodeN  = rspCode;
    haltN     = 1'b0;
    rebootN   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.sendReq = 1'b1;
          nState      = ST_WAIT;
        end else if (irqLine && (rxIsHalt || rxIsReboot)) begin
          ctl.sendEcho = 1'b1;
          ctl.ackRx    = 1'b1;
          haltN        = rxIsHalt;
          rebootN      = rxIsReboot;
        end
      end
      default: begin
        ctl.timerRun = 1'b1;
        busyN        = reqValid;
        if (irqLine) begin
          ctl.ackRx = 1'b1;
          rspValidN = 1'b1;
          rspCodeN  = rxMatch ? RSP_OK : RSP_MISMATCH;
          nState    = ST_IDLE;
        end else if (timeoutHit) begin
          rspValidN = 1'b1;
          rspCodeN  = RSP_TIMEOUT;
          nState    = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      reqBusy     <= 1'b0;
      rspValid    <= 1'b0;
      rspCode     <= RSP_NONE;
      haltPulse   <= 1'b0;
      rebootPulse <= 1'b0;
    end else begin
      state       <= nState;
      reqBusy     <= busyN;
      rspValid    <= rspValidN;
      rspCode     <= rspCodeN;
      haltPulse   <= haltN;
      rebootPulse <= rebootN;
    end
  end

  p_busy_when_waiting_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqBusy |-> $past(state) == ST_WAIT && $past(reqValid));
  p_rsp_ends_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(state) == ST_WAIT && state == ST_IDLE);
  p_action_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({haltPulse, rebootPulse, rspValid}));
endmodule

// File: rtl/mbox_echo_link.sv
module mbox_echo_link
  import mbox_echo_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int WINDOW_MS = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqToken,
  output logic        reqBusy,
  output logic        rspValid,
  output logic [1:0]  rspCode,
  output logic        mbxOutValid,
  output logic [31:0] mbxOutData,
  input  logic        mbxInValid,
  input  logic [31:0] mbxInData,
  input  logic        icWrite,
  input  logic [31:0] icData,
  output logic [31:0] statusWord,
  output logic        irqOut,
  input  logic        consoleRst,
  input  logic        regLock,
  output logic        haltPulse,
  output logic        rebootPulse
);
  localparam int TIMEOUT_CYCLES = (CLK_HZ / 1000) * WINDOW_MS;

  ctlStrobe_t ctl;
  rspCode_e   rspCodeE;
  logic       rxMatch, rxIsHalt, rxIsReboot, timeoutHit;

  mbox_echo_dp #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqToken(reqToken),
    .mbxInValid(mbxInValid), .mbxInData(mbxInData),
    .icWrite(icWrite), .icData(icData), .flush(consoleRst || regLock),
    .mbxOutValid(mbxOutValid), .mbxOutData(mbxOutData),
    .irqLine(irqOut), .statusWord(statusWord),
    .rxMatch(rxMatch), .rxIsHalt(rxIsHalt), .rxIsReboot(rxIsReboot),
    .timeoutHit(timeoutHit)
  );

  mbox_echo_ctl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .irqLine(irqOut),
    .rxMatch(rxMatch), .rxIsHalt(rxIsHalt), .rxIsReboot(rxIsReboot),
    .timeoutHit(timeoutHit), .ctl(ctl), .reqBusy(reqBusy),
    .rspValid(rspValid), .rspCode(rspCodeE),
    .haltPulse(haltPulse), .rebootPulse(rebootPulse)
  );

  assign rspCode = rspCodeE;

  p_halt_echo_r9: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> mbxOutValid && mbxOutData == HALT_TOKEN);
  p_reboot_echo_r9: assert property (@(posedge clk) disable iff (!rstN)
    rebootPulse |-> mbxOutValid && mbxOutData == REBOOT_TOKEN);
  p_busy_no_send_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqBusy |-> !mbxOutValid);
endmodule

// File: tb/tb_mbox_echo_link.sv
module tb_mbox_echo_link;
  localparam int TO = 40;  // CLK_HZ 40000, WINDOW_MS 1

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, mbxInValid = 0, icWrite = 0, consoleRst = 0, regLock = 0;
  logic [31:0] reqToken = '0, mbxInData = '0, icData = '0;
  logic reqBusy, rspValid, mbxOutValid, irqOut, haltPulse, rebootPulse;
  logic [1:0] rspCode;
  logic [31:0] mbxOutData, statusWord;
  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  mbox_echo_link #(.CLK_HZ(40000), .WINDOW_MS(1)) dut (.*);

  // token, reply, delay (0 = none), expected code
  localparam logic [31:0] V_TOK[5] = '{32'h1234_5678, 32'hFF00_0001, 32'hCAFE_0000, 32'h0000_0001, 32'h0000_ABCD};
  localparam logic [31:0] V_REP[5] = '{32'h1234_5678, 32'hFF00_0001, 32'hCAFE_0001, 32'h0,         32'h0000_ABCD};
  localparam int          V_DLY[5] = '{3, 10, 5, 0, 39};
  localparam logic [1:0]  V_EXP[5] = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic icw(input logic [31:0] d);
    @(negedge clk); icWrite = 1; icData = d;
    @(negedge clk); icWrite = 0; icData = '0;
  endtask

  task automatic inject(input logic [31:0] d);
    @(negedge clk); mbxInValid = 1; mbxInData = d;
    @(negedge clk); mbxInValid = 0;
  endtask

  task automatic runReq(input logic [31:0] tok, input logic [31:0] rep, input int d,
                        output logic [1:0] code, output int at);
    at = -1; code = 2'd0;
    @(negedge clk); reqValid = 1; reqToken = tok;
    for (int k = 1; k <= TO + 3; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk("R2 out valid", {31'd0, mbxOutValid}, 32'd1);
        chk("R2 out data", mbxOutData, tok);
      end
      if (rspValid && at < 0) begin at = k - 1; code = rspCode; end
      reqValid   = 0;
      mbxInValid = (d != 0 && k == d);
      mbxInData  = rep;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [1:0] code;
    int at;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", statusWord, 32'd0);
    chk("R1 outputs", {26'd0, irqOut, rspValid, reqBusy, mbxOutValid, haltPulse, rebootPulse}, 32'd0);

    // R5: interrupt gated off, reply ignored -> timeout, flag left pending (R7)
    runReq(32'h0000_7777, 32'h0000_7777, 2, code, at);
    chk("R5 gated timeout code", code, 32'd3);
    chk("R5 gated timeout edge", at, TO);
    chk("R7 pending without enable", statusWord, 32'h0080_0000);
    chk("R7 irq needs enable", irqOut, 1'b0);
    icw(32'h1000_0000);
    chk("R8 clear bit 28", statusWord, 32'd0);

    icw(32'h0000_0100);
    chk("R7 enable bit 22", statusWord, 32'h0040_0000);

    // table of exchanges: R3, R4, R5
    for (int i = 0; i < 5; i++) begin
      runReq(V_TOK[i], V_REP[i], V_DLY[i], code, at);
      chk($sformatf("R3/R4/R5 vec%0d code", i), code, V_EXP[i]);
      chk($sformatf("R3/R4/R5 vec%0d edge", i), at, (V_DLY[i] != 0) ? V_DLY[i] + 1 : TO);
      chk($sformatf("R3 vec%0d pending cleared", i), statusWord, 32'h0040_0000);
    end

    // R6 busy refusal
    @(negedge clk); reqValid = 1; reqToken = 32'h0000_AAAA;
    @(negedge clk); reqToken = 32'h0000_BBBB;
    @(negedge clk);
    chk("R6 busy", reqBusy, 1'b1);
    chk("R6 no outbound", mbxOutValid, 1'b0);
    reqValid = 0; mbxInValid = 1; mbxInData = 32'h0000_AAAA;
    @(negedge clk); mbxInValid = 0;
    @(negedge clk);
    chk("R6 original ok", {rspValid, rspCode}, 3'b101);
    begin
      int seen = 0;
      repeat (6) begin @(negedge clk); if (mbxOutValid || rspValid) seen++; end
      chk("R6 not queued", seen, 0);
    end

    // R9 halt echo, then reboot still answered
    inject(32'hFF00_0001);
    @(negedge clk);
    chk("R9 halt pulse", {haltPulse, rebootPulse, mbxOutValid}, 3'b101);
    chk("R9 halt echo", mbxOutData, 32'hFF00_0001);
    chk("R9 halt pending cleared", statusWord, 32'h0040_0000);
    inject(32'hFF00_0002);
    @(negedge clk);
    chk("R9 reboot after halt", {haltPulse, rebootPulse, mbxOutValid}, 3'b011);
    chk("R9 reboot echo", mbxOutData, 32'hFF00_0002);

    // R10 undefined reserved and user tokens are left alone
    inject(32'hFF00_0003);
    begin
      int seen = 0;
      repeat (4) begin @(negedge clk); if (mbxOutValid || haltPulse || rebootPulse) seen++; end
      chk("R10 reserved undefined not echoed", seen, 0);
    end
    chk("R10 reserved stays pending", statusWord, 32'h00C0_0000);
    icw(32'h1000_0000);
    inject(32'h0000_0055);
    @(negedge clk);
    chk("R10 user token not echoed", mbxOutValid, 1'b0);
    chk("R10 user token pending", irqOut, 1'b1);

    // R11 flush by console reset and by lock
    @(negedge clk); consoleRst = 1;
    @(negedge clk); consoleRst = 0;
    chk("R11 console reset flush", statusWord, 32'd0);
    icw(32'h0000_0100);
    inject(32'h0000_0066);
    @(negedge clk); regLock = 1;
    @(negedge clk); regLock = 0;
    chk("R11 lock flush", {statusWord[31:1], irqOut}, 32'd0);

    // R8 set and clear together -> disabled; arrival beats clear
    icw(32'h0000_0300);
    chk("R8 disable wins", statusWord, 32'd0);
    @(negedge clk); mbxInValid = 1; mbxInData = 32'h0000_0077; icWrite = 1; icData = 32'h1000_0000;
    @(negedge clk); mbxInValid = 0; icWrite = 0; icData = '0;
    chk("R8 arrival beats clear", statusWord, 32'h0080_0000);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule